// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block translates accesses to a bit-alias window into accesses to a byte-addressable target region. Inside the window, every 32-bit alias word stands for exactly one bit of the target. The bridge takes single requests of byte, halfword or word size at a window offset. It works out which target unit and which bit the offset selects, and issues the matching access on its master port.

A read returns the selected bit as 0 or 1. A write becomes an indivisible read-modify-write: the bridge reads the unit, sets or clears the one bit, and writes the unit back. The lock output stays high for the whole sequence so that nothing else can reach the target in between. The bridge holds off new requests until the sequence is complete.

The target base and the window width are parameters. Two typical instantiations use target base 0x2000_0000 behind a window at 0x2200_0000, and target base 0x4000_0000 behind a window at 0x4200_0000. The window decode sits outside the block, so the slave port carries only the offset into the window.

Top module: `bitband_bridge`

## Requirements
- R1: Size code 0 is byte, 1 is halfword and 2 is word. The target unit address on `m_req_addr` is TGT_BASE OR (offset >> 5). For a halfword, bit 0 of that address is then cleared. For a word, bits 1:0 are cleared.
- R2: The bit index is offset[4:2] for a byte, offset[5:2] for a halfword and offset[6:2] for a word. The target is little-endian: the bit lives in byte (index / 8) of the unit, at bit position (index mod 8) of that byte.
- R3: A read response carries the selected bit in `s_rsp_rdata[0]`, and bits 31:1 are zero.
- R4: A write reads the unit and then writes it back with only the selected bit changed, set to `s_req_wdata[0]`. Bits 31:1 of the write data have no effect, and every other bit of the unit keeps its value.
- R5: The byte enables are as follows. A byte access enables the single lane addr[1:0]. A halfword access enables 4'b0011 when addr[1] is 0 and 4'b1100 when it is 1. A word access enables 4'b1111. Data sits on the lanes in little-endian order.
- R6: For a write, `m_lock` is high from the issue of the target read until the write-back is accepted. It is low during reads.
- R7: `s_req_ready` drops the cycle after a request is accepted and stays low until the response has been given. Only one target access is outstanding at a time.
- R8: `s_rsp_valid` is a one-cycle pulse in the cycle after the last master event. For a read, that event is the read data strobe. For a write, it is the acceptance of the write-back.
- R9: After a synchronous active-low reset the bridge is idle. `s_req_ready` is high, and `m_req_valid`, `m_lock` and `s_rsp_valid` are low.
- R10: While `m_req_valid` is high and `m_req_ready` is low, every master request field holds steady, so any number of target wait states is tolerated.
- R11: The response to a write carries the value the selected bit held before the write, in bit 0, with bits 31:1 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_req_valid | input | 1 | Alias request valid |
| s_req_ready | output | 1 | Bridge can accept a request |
| s_req_write | input | 1 | 1 = write, 0 = read |
| s_req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| s_req_offset | input | WIN_BITS | Offset inside the alias window |
| s_req_wdata | input | 32 | Write data; only bit 0 matters |
| s_rsp_valid | output | 1 | One-cycle response pulse |
| s_rsp_rdata | output | 32 | Selected bit in bit 0 |
| m_req_valid | output | 1 | Target request valid |
| m_req_ready | input | 1 | Target accepts the request |
| m_req_write | output | 1 | Target write (write-back) |
| m_req_size | output | 2 | Size of the target access |
| m_req_addr | output | ADDR_W | Size-aligned target address |
| m_req_be | output | 4 | Byte enables |
| m_req_wdata | output | 32 | Write-back data on lanes |
| m_lock | output | 1 | Target locked for read-modify-write |
| m_rsp_valid | input | 1 | Target read data strobe |
| m_rsp_rdata | input | 32 | Target read data (aligned word) |

## Verification
The response pulse is due exactly one cycle after the last master event. For a read, that event is the edge that samples the read data strobe. For a write, it is the edge that accepts the write-back. The bench's target model records the cycle number of that event, and the slave task compares it with the cycle in which it sees `s_rsp_valid`. The model also records the address, byte enables and lock seen at each target handshake, and checks them once the response arrives. This works under randomised ready and data wait states because the model does not rely on fixed latencies. The bench samples at the falling edge, and it checks one cycle after each response that the pulse has dropped. Target memory is compared word by word against an independent shadow model at the end.

// File: rtl/bb_pkg.sv
// Shared types for the bit-alias bridge.
// Assumes a 32-bit little-endian target data bus.
package bb_pkg;
    localparam int BB_DATA_W = 32;
    localparam int BB_STRB_W = BB_DATA_W / 8;
    localparam int BB_LANE_W = $clog2(BB_DATA_W);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } bb_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_RESP
    } bb_state_e;
endpackage

// File: rtl/bb_addr_map.sv
// Maps an alias-window offset and an access size to a size-aligned target
// address, byte enables and the bit's position on the 32-bit data bus.
// Assumes TGT_BASE has zeros where the shifted offset lands (OR == add).
module bb_addr_map
    import bb_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                WIN_BITS = 25,
    parameter logic [ADDR_W-1:0] TGT_BASE = 32'h2000_0000
) (
    input  logic [WIN_BITS-1:0]  offset,
    input  logic [1:0]           size,
    output logic [ADDR_W-1:0]    tgt_addr,
    output logic [BB_STRB_W-1:0] be,
    output logic [BB_LANE_W-1:0] lane_bit
);
    localparam int UNIT_SHIFT = 5;

    logic [ADDR_W-1:0] raw_addr;

    // Purpose: base OR shifted offset gives the unaligned target byte.
    always_comb raw_addr = TGT_BASE | ADDR_W'(offset >> UNIT_SHIFT);

    // Purpose: align per size and derive enables and bus bit position.
    always_comb begin
        case (size)
            SZ_BYTE: begin
                tgt_addr = raw_addr;
                be       = BB_STRB_W'(1) << raw_addr[1:0];
                lane_bit = {raw_addr[1:0], 3'b000} + {2'b00, offset[4:2]};
            end
            SZ_HALF: begin
                tgt_addr = {raw_addr[ADDR_W-1:1], 1'b0};
                be       = raw_addr[1] ? 4'b1100 : 4'b0011;
                lane_bit = {raw_addr[1], 4'b0000} + {1'b0, offset[5:2]};
            end
            default: begin
                tgt_addr = {raw_addr[ADDR_W-1:2], 2'b00};
                be       = 4'b1111;
                lane_bit = offset[6:2];
            end
        endcase
    end
endmodule

// File: rtl/bb_bit_ops.sv
// Extracts one bit from a bus word and builds the word with that bit
// forced to a new value. Purely combinational.
module bb_bit_ops
    import bb_pkg::*;
(
    input  logic [BB_DATA_W-1:0] word_in,
    input  logic [BB_LANE_W-1:0] pos,
    input  logic                 new_val,
    output logic                 bit_out,
    output logic [BB_DATA_W-1:0] word_out
);
    logic [BB_DATA_W-1:0] sel_mask;

    // Purpose: one-hot mask, bit pick and set/clear.
    always_comb begin
        sel_mask = BB_DATA_W'(1) << pos;
        bit_out  = |(word_in & sel_mask);
        word_out = new_val ? (word_in | sel_mask) : (word_in & ~sel_mask);
    end
endmodule

// File: rtl/bitband_bridge.sv
// Bit-alias bridge top. Accepts one alias request at a time and sequences
// read, optional locked write-back and a one-cycle response.
// Assumes the window decode is done outside; only the offset arrives.
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                WIN_BITS = 25,
    parameter logic [ADDR_W-1:0] TGT_BASE = 32'h2000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_req_valid,
    output logic                 s_req_ready,
    input  logic                 s_req_write,
    input  logic [1:0]           s_req_size,
    input  logic [WIN_BITS-1:0]  s_req_offset,
    input  logic [BB_DATA_W-1:0] s_req_wdata,
    output logic                 s_rsp_valid,
    output logic [BB_DATA_W-1:0] s_rsp_rdata,
    output logic                 m_req_valid,
    input  logic                 m_req_ready,
    output logic                 m_req_write,
    output logic [1:0]           m_req_size,
    output logic [ADDR_W-1:0]    m_req_addr,
    output logic [BB_STRB_W-1:0] m_req_be,
    output logic [BB_DATA_W-1:0] m_req_wdata,
    output logic                 m_lock,
    input  logic                 m_rsp_valid,
    input  logic [BB_DATA_W-1:0] m_rsp_rdata
);
    bb_state_e             state;
    logic                  req_write;
    logic [1:0]            req_size;
    logic [WIN_BITS-1:0]   req_off;
    logic                  req_set;
    logic [BB_DATA_W-1:0]  rd_word;
    logic [BB_LANE_W-1:0]  lane_bit;
    logic                  cur_bit;
    logic [BB_DATA_W-1:0]  mod_word;

    bb_addr_map #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .TGT_BASE(TGT_BASE)) u_map (
        .offset   (req_off),
        .size     (req_size),
        .tgt_addr (m_req_addr),
        .be       (m_req_be),
        .lane_bit (lane_bit)
    );

    bb_bit_ops u_bits (
        .word_in  (rd_word),
        .pos      (lane_bit),
        .new_val  (req_set),
        .bit_out  (cur_bit),
        .word_out (mod_word)
    );

    // Purpose: sequence idle -> read -> (write-back) -> respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            req_write <= 1'b0;
            req_size  <= SZ_BYTE;
            req_off   <= '0;
            req_set   <= 1'b0;
            rd_word   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (s_req_valid) begin
                    req_write <= s_req_write;
                    req_size  <= s_req_size;
                    req_off   <= s_req_offset;
                    req_set   <= s_req_wdata[0];
                    state     <= ST_RD_REQ;
                end
                ST_RD_REQ: if (m_req_ready) state <= ST_RD_WAIT;
                ST_RD_WAIT: if (m_rsp_valid) begin
                    rd_word <= m_rsp_rdata;
                    state   <= req_write ? ST_WR_REQ : ST_RESP;
                end
                ST_WR_REQ: if (m_req_ready) state <= ST_RESP;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive port outputs from the current state.
    always_comb begin
        s_req_ready = (state == ST_IDLE);
        s_rsp_valid = (state == ST_RESP);
        s_rsp_rdata = {{(BB_DATA_W-1){1'b0}}, cur_bit & s_rsp_valid};
        m_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
        m_req_write = (state == ST_WR_REQ);
        m_req_size  = req_size;
        m_req_wdata = m_req_write ? mod_word : '0;
        m_lock      = req_write && ((state == ST_RD_REQ) || (state == ST_RD_WAIT)
                                    || (state == ST_WR_REQ));
    end
endmodule

// File: rtl/bb_bridge_chk.sv
// Protocol checker for the bit-alias bridge, bound to the top module.
module bb_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        s_req_valid,
    input logic        s_req_ready,
    input logic        s_rsp_valid,
    input logic [31:0] s_rsp_rdata,
    input logic        m_req_valid,
    input logic        m_req_ready,
    input logic        m_req_write,
    input logic [31:0] m_req_addr,
    input logic [3:0]  m_req_be,
    input logic [31:0] m_req_wdata,
    input logic        m_lock
);
    assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_req_valid && s_req_ready |=> !s_req_ready);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_req_ready |-> !m_req_valid && !m_lock && !s_rsp_valid);

    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_valid |=> !s_rsp_valid);

    assert_rsp_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_valid |-> s_rsp_rdata[31:1] == 31'd0);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        m_req_valid && !m_req_ready |=> m_req_valid && $stable(m_req_addr)
            && $stable(m_req_write) && $stable(m_req_be) && $stable(m_req_wdata));

    assert_wb_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_req_valid && m_req_write |-> m_lock);

    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_lock && !(m_req_valid && m_req_write && m_req_ready) |=> m_lock);

    assert_be_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_req_valid |-> ($countones(m_req_be) == 1 || m_req_be == 4'b0011
                         || m_req_be == 4'b1100 || m_req_be == 4'b1111));
endmodule

bind bitband_bridge bb_bridge_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_req_valid (s_req_valid),
    .s_req_ready (s_req_ready),
    .s_rsp_valid (s_rsp_valid),
    .s_rsp_rdata (s_rsp_rdata),
    .m_req_valid (m_req_valid),
    .m_req_ready (m_req_ready),
    .m_req_write (m_req_write),
    .m_req_addr  (m_req_addr),
    .m_req_be    (m_req_be),
    .m_req_wdata (m_req_wdata),
    .m_lock      (m_lock)
);

// File: tb/bitband_bridge_bench.sv
`timescale 1ns/1ps
module bitband_bridge_bench;
    localparam logic [31:0] TGT = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_req_valid = 1'b0;
    logic        s_req_ready;
    logic        s_req_write = 1'b0;
    logic [1:0]  s_req_size = 2'd0;
    logic [24:0] s_req_offset = '0;
    logic [31:0] s_req_wdata = '0;
    logic        s_rsp_valid;
    logic [31:0] s_rsp_rdata;
    logic        m_req_valid;
    logic        m_req_ready = 1'b0;
    logic        m_req_write;
    logic [1:0]  m_req_size;
    logic [31:0] m_req_addr;
    logic [3:0]  m_req_be;
    logic [31:0] m_req_wdata;
    logic        m_lock;
    logic        m_rsp_valid = 1'b0;
    logic [31:0] m_rsp_rdata = '0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    bitband_bridge #(.ADDR_W(32), .WIN_BITS(25), .TGT_BASE(TGT)) u_bitband_bridge (.*);

    always #2.5 clk = ~clk;

    // Memories: word-keyed; untouched words read as a fixed hash.
    logic [31:0] tmem [int unsigned];
    logic [31:0] smem [int unsigned];

    function automatic logic [31:0] seed_word(int unsigned k);
        return (k * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction
    function automatic logic [31:0] tget(int unsigned k);
        return tmem.exists(k) ? tmem[k] : seed_word(k);
    endfunction
    function automatic logic [31:0] sget(int unsigned k);
        return smem.exists(k) ? smem[k] : seed_word(k);
    endfunction

    // Target model state
    int          cyc = 0;
    int          last_evt = -10;
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    bit          pend = 1'b0;
    int          dly = 0;
    logic [31:0] ob_rd_addr, ob_wr_addr;
    logic [3:0]  ob_rd_be, ob_wr_be;
    logic        ob_rd_lock;

    always @(posedge clk) begin
        logic [31:0] w;
        cyc         <= cyc + 1;
        m_req_ready <= ($urandom % 3) != 0;
        m_rsp_valid <= 1'b0;
        if (m_rsp_valid) last_evt <= cyc;
        if (rst_n && m_req_valid && m_req_ready) begin
            if (!m_req_write) begin
                ob_rd_addr <= m_req_addr;
                ob_rd_be   <= m_req_be;
                ob_rd_lock <= m_lock;
                rd_cnt     <= rd_cnt + 1;
                pend       <= 1'b1;
                dly        <= int'($urandom % 3);
            end else begin
                w = tget(m_req_addr >> 2);
                for (int b = 0; b < 4; b++)
                    if (m_req_be[b]) w[8*b +: 8] = m_req_wdata[8*b +: 8];
                tmem[m_req_addr >> 2] = w;
                ob_wr_addr <= m_req_addr;
                ob_wr_be   <= m_req_be;
                wr_cnt     <= wr_cnt + 1;
                last_evt   <= cyc;
            end
        end
        if (pend) begin
            if (dly == 0) begin
                m_rsp_valid <= 1'b1;
                m_rsp_rdata <= tget(ob_rd_addr >> 2);
                pend        <= 1'b0;
            end else dly <= dly - 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(logic [1:0] sz, logic [24:0] off);
        logic [31:0] a = TGT | (32'(off) >> 5);
        if (sz == 2'd1) a[0] = 1'b0;
        else if (sz == 2'd2) a[1:0] = 2'b00;
        return a;
    endfunction
    function automatic int exp_idx(logic [1:0] sz, logic [24:0] off);
        return (sz == 2'd0) ? int'(off[4:2]) : (sz == 2'd1) ? int'(off[5:2]) : int'(off[6:2]);
    endfunction
    function automatic logic [3:0] exp_be(logic [1:0] sz, logic [31:0] a);
        if (sz == 2'd0) return 4'b0001 << a[1:0];
        if (sz == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    task automatic access(input bit wr, input logic [1:0] sz, input logic [24:0] off, input logic [31:0] wd);
        logic [31:0] ua = exp_addr(sz, off);
        int          ix = exp_idx(sz, off);
        logic [31:0] ba = ua + 32'(ix / 8);
        int unsigned key = ba >> 2;
        int          pos = int'(ba[1:0]) * 8 + ix % 8;
        logic [31:0] sw = sget(key);
        logic        old_bit = sw[pos];
        int          w0 = wr_cnt;
        int          r0 = rd_cnt;
        int          n = 0;
        s_req_write  = wr;
        s_req_size   = sz;
        s_req_offset = off;
        s_req_wdata  = wd;
        s_req_valid  = 1'b1;
        while (!s_req_ready) @(negedge clk);
        @(negedge clk);
        s_req_valid = 1'b0;
        check(!s_req_ready, "R7 ready low while busy", 32'(s_req_ready), 0);
        while (!s_rsp_valid && n < 100) begin @(negedge clk); n++; end
        check(s_rsp_valid, "R8 response arrives", 32'(s_rsp_valid), 1);
        check(cyc == last_evt + 1, "R8 response one cycle after last target event", 32'(cyc), 32'(last_evt + 1));
        check(rd_cnt == r0 + 1 && ob_rd_addr == ua, "R1 target read address", ob_rd_addr, ua);
        check(ob_rd_be == exp_be(sz, ua), "R5 read byte enables", 32'(ob_rd_be), 32'(exp_be(sz, ua)));
        check(ob_rd_lock == wr, "R6 lock during target read", 32'(ob_rd_lock), 32'(wr));
        if (wr) begin
            check(s_rsp_rdata == 32'(old_bit), "R11 write response carries prior bit", s_rsp_rdata, 32'(old_bit));
            check(wr_cnt == w0 + 1 && ob_wr_addr == ua && ob_wr_be == exp_be(sz, ua),
                  "R4 single write-back to same unit", ob_wr_addr, ua);
            sw[pos]   = wd[0];
            smem[key] = sw;
            check(tget(key) == sw, "R2 R4 target word after bit update", tget(key), sw);
        end else begin
            check(s_rsp_rdata == 32'(old_bit), "R2 R3 read returns selected bit", s_rsp_rdata, 32'(old_bit));
            check(wr_cnt == w0, "R6 no write on read", 32'(wr_cnt), 32'(w0));
        end
        @(negedge clk);
        check(!s_rsp_valid, "R8 response is a single pulse", 32'(s_rsp_valid), 0);
    endtask

    initial begin
        int unsigned seed_dummy = $urandom(32'd20240611);
        if (seed_dummy == 0) ; // fixed seed applied
        repeat (3) @(negedge clk);
        check(s_req_ready && !m_req_valid && !m_lock && !s_rsp_valid, "R9 reset state",
              {28'd0, s_req_ready, m_req_valid, m_lock, s_rsp_valid}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check(s_req_ready && !m_req_valid && !s_rsp_valid, "R9 idle after reset",
              {30'd0, s_req_ready, m_req_valid}, 32'h2);
        // Directed corners: first/last window words, first/last bit per size
        access(1'b1, 2'd0, 25'h000_0000, 32'hFFFF_FFFF);
        access(1'b0, 2'd0, 25'h000_0000, 32'h0);
        access(1'b1, 2'd0, 25'h000_001C, 32'h0);
        access(1'b1, 2'd0, 25'h000_001C, 32'hFFFF_FFFE);   // R4: bit0 is 0 -> clear
        access(1'b0, 2'd0, 25'h000_001C, 32'h0);
        access(1'b1, 2'd1, 25'h000_003C, 32'h1);
        access(1'b0, 2'd1, 25'h000_003C, 32'h0);
        access(1'b1, 2'd2, 25'h000_007C, 32'h1);
        access(1'b0, 2'd2, 25'h000_007C, 32'h0);
        access(1'b1, 2'd2, 25'h1FF_FFFC, 32'h0);
        access(1'b0, 2'd2, 25'h1FF_FFFC, 32'h0);
        access(1'b1, 2'd0, 25'h1FF_FFFC, 32'h1);
        access(1'b1, 2'd1, 25'h1FF_FFE0, 32'h0);
        access(1'b0, 2'd0, 25'h1FF_FFFC, 32'h0);
        // Random mix in a small region so bits are revisited
        for (int i = 0; i < 600; i++) begin
            logic [24:0] off;
            logic [1:0]  sz = 2'($urandom % 3);
            off = ($urandom % 4 == 0) ? 25'($urandom) : 25'(($urandom % 64) << 5) | 25'($urandom % 128);
            access(1'($urandom % 2), sz, off, $urandom);
        end
        // R4: every touched word matches the shadow model
        begin
            int bad = 0;
            foreach (smem[k]) if (tget(k) != smem[k]) bad++;
            foreach (tmem[k]) if (tmem[k] != sget(k)) bad++;
            check(bad == 0, "R4 memory matches shadow", 32'(bad), 0);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule